// File: doc/BRIEF.md
# I2S Master Audio Port

This block is a full-duplex audio serial port that acts as clock master for the
serial link. It produces the bit clock and the word-select (left/right) clock
itself, shifts 16-bit stereo samples out on the serial data line, and shifts
received samples in from the serial data input. Every channel slot is 32 bit
clocks long, so one frame is 64 bit clocks. The first 16 bits of a slot carry the
sample, most significant bit first. The remaining 16 bits are padding.

On the system side, the port reads a show-ahead transmit FIFO and writes a
receive FIFO. A FIFO word is 32 bits wide, and the sample sits in the upper half.
The bit rate comes from an external divider. Every pulse on `bclk_en_i` advances
the serial clock by one half period.

Transmit and receive are enabled separately. An enable takes effect only at a
frame boundary. When both enables are cleared, the port finishes the frame in
progress and then reports idle. If the continuous option is set, the bit clock
and word select keep running with no data traffic.

Top module: `i2s_master_port`

## Requirements
- R1: After reset, `bclk_o` equals `bclk_inv_i` and `lrck_o` equals `lrck_inv_i`. `sdo_o` is 0 and `idle_o` is 1. No FIFO strobe (`tx_rd_o`, `tx_underrun_o`, `rx_wr_o`, `rx_overrun_o`) is active.
- R2: While the port runs, each `bclk_en_i` pulse toggles `bclk_o` once, and a frame spans 64 bit-clock periods. With `bclk_inv_i`=0, data changes after a falling edge and is sampled on the rising edge. With `bclk_inv_i`=1, the pin is inverted.
- R3: With `lrck_inv_i`=0, `lrck_o` is low for the left slot and high for the right slot. It changes one bit clock before each slot's MSB, so the left channel begins at a falling edge. `lrck_inv_i`=1 inverts the pin.
- R4: In an active transmit slot, `sdo_o` carries bits 31:16 of the FIFO word, MSB first, in bit positions 0 to 15 of the slot. It is 0 in positions 16 to 31.
- R5: For each slot of an active transmit frame, one `tx_rd_o` pulse is issued. The pulse comes in the clock cycle where the slot's first bit is driven, and only when `tx_empty_i` is 0. The left slot is served first.
- R6: If `tx_empty_i` is 1 at the start of an active transmit slot, `tx_underrun_o` pulses for one cycle and the slot is sent as zeros.
- R7: In an active receive slot, `rx_sdi_i` is sampled on the rising edges of positions 0 to 15, MSB first. At the falling edge that ends the slot, `rx_wr_o` pulses with `rx_data_o` = {sample, 16'h0}.
- R8: If `rx_full_i` is 1 when a received sample is due, `rx_overrun_o` pulses, `rx_wr_o` stays low and the sample is dropped.
- R9: Transmit and receive enables act independently. With only transmit on, there are no receive writes. With only receive on, there are no transmit reads.
- R10: Clearing the enables mid-frame lets the frame complete. After that, `idle_o` rises and, without the continuous option, `bclk_o` and `lrck_o` stop toggling.
- R11: With `lrck_cont_i`=1 and both enables low, the clocks keep toggling. `sdo_o` stays 0, there is no FIFO traffic, and `idle_o` is 1.
- R12: An enable raised while the clocks already run takes effect only at the next frame start. The first read therefore belongs to a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en_i | input | 1 | Half-period advance pulse from the rate divider |
| bclk_inv_i | input | 1 | Invert bit-clock pin polarity |
| lrck_inv_i | input | 1 | Invert word-select pin polarity |
| lrck_cont_i | input | 1 | Keep clocks running while both directions are off |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| tx_data_i | input | 32 | Head word of the transmit FIFO (show-ahead) |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_rd_o | output | 1 | Pop strobe for the transmit FIFO |
| tx_underrun_o | output | 1 | Transmit slot started with an empty FIFO |
| rx_sdi_i | input | 1 | Serial data input |
| rx_data_o | output | 32 | Received word, sample in bits 31:16 |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_wr_o | output | 1 | Push strobe for the receive FIFO |
| rx_overrun_o | output | 1 | Received sample dropped on a full FIFO |
| bclk_o | output | 1 | Bit clock pin |
| lrck_o | output | 1 | Word-select pin |
| sdo_o | output | 1 | Serial data output |
| idle_o | output | 1 | No direction enabled or finishing a frame |

## Verification
The hardest case to reach is a change of enable that does not line up with a frame boundary. Examples are a stop request in the middle of a slot, and a start while the continuous clocks are already running at an arbitrary bit position. To get there, the stimulus switches enables at cycle counts unrelated to the frame length and uses irregular, random divider pulses. A behavioural model tracks the frame position and compares every output on every cycle. Small FIFO fill levels cause underrun and overrun to happen in the middle of a run rather than only at its edges.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

  // Serial-clock events for one system clock cycle
  typedef struct packed {
    logic rise;       // bit clock goes to its sampling phase
    logic fall;       // bit clock goes to its launch phase
    logic wrap;       // fall on the last bit of a frame
    logic slot_open;  // fall that launches bit 0 of a slot
  } tick_ev_t;

endpackage

// File: rtl/i2s_timebase.sv
module i2s_timebase
  import i2s_port_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bclk_en_i,
  input  logic                  keep_i,
  output tick_ev_t              ev_o,
  output logic [$clog2(SLOT_BITS)-1:0] cur_bit_o,
  output logic [$clog2(SLOT_BITS)-1:0] nxt_bit_o,
  output logic                  phase_o,
  output logic                  ws_o
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SP_W       = $clog2(SLOT_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic             run_q, ph_q;
  logic [POS_W-1:0] pos_q, pos_nxt, pos_ahead;
  logic             rise_w, fall_w, wrap_w, halt_w, open_w;

  // one position ahead with wrap, used for launch and word-select lead
  function automatic logic [POS_W-1:0] step_pos(input logic [POS_W-1:0] p);
    return (p == LAST_POS) ? '0 : p + 1'b1;
  endfunction

  assign rise_w    = run_q & bclk_en_i & ~ph_q;
  assign fall_w    = run_q & bclk_en_i & ph_q;
  assign wrap_w    = fall_w & (pos_q == LAST_POS);
  assign halt_w    = wrap_w & ~keep_i;
  assign pos_nxt   = halt_w ? pos_q : step_pos(pos_q);
  assign open_w    = fall_w & ~halt_w & (pos_nxt[SP_W-1:0] == '0);
  assign pos_ahead = step_pos(pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      pos_q <= LAST_POS;
    end else begin
      if (!run_q && keep_i) run_q <= 1'b1;
      if (rise_w) ph_q <= 1'b1;
      if (fall_w) begin
        ph_q  <= 1'b0;
        pos_q <= pos_nxt;
        if (halt_w) run_q <= 1'b0;
      end
    end
  end

  assign ev_o      = '{rise: rise_w, fall: fall_w, wrap: wrap_w, slot_open: open_w};
  assign cur_bit_o = pos_q[SP_W-1:0];
  assign nxt_bit_o = pos_nxt[SP_W-1:0];
  assign phase_o   = ph_q;
  assign ws_o      = pos_ahead[POS_W-1];

  AST_PARKED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pos_q == LAST_POS && !ph_q)); // R10
  AST_WS_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> $past(fall_w)); // R3
  AST_PHASE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_q) |-> $past(bclk_en_i)); // R2
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
  import i2s_port_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 16,
  parameter int FIFO_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tick_ev_t              ev_i,
  input  logic [$clog2(SLOT_BITS)-1:0] nxt_bit_i,
  input  logic                  en_i,
  input  logic [FIFO_W-1:0]     data_i,
  input  logic                  empty_i,
  output logic                  rd_o,
  output logic                  underrun_o,
  output logic                  sdo_o,
  output logic                  act_o
);
  localparam int SP_W = $clog2(SLOT_BITS);
  localparam int PAD_W = FIFO_W - SAMPLE_BITS;

  logic                   act_q, act_nxt, sdo_q;
  logic [SAMPLE_BITS-1:0] word_q, load_w;
  logic                   unused_in;

  // bit of the sample at a slot position; zero in the padding area
  function automatic logic pick_bit(input logic [SAMPLE_BITS-1:0] w,
                                    input logic [SP_W-1:0] p);
    logic [SAMPLE_BITS-1:0] s;
    s = w << p;
    return (int'(p) < SAMPLE_BITS) ? s[SAMPLE_BITS-1] : 1'b0;
  endfunction

  assign act_nxt    = ev_i.wrap ? en_i : act_q;
  assign load_w     = empty_i ? '0 : data_i[FIFO_W-1 -: SAMPLE_BITS];
  assign rd_o       = ev_i.slot_open & act_nxt & ~empty_i;
  assign underrun_o = ev_i.slot_open & act_nxt & empty_i;
  assign unused_in  = ^{ev_i.rise, data_i[PAD_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      word_q <= '0;
      sdo_q  <= 1'b0;
    end else if (ev_i.fall) begin
      act_q <= act_nxt;
      if (ev_i.slot_open && act_nxt) begin
        word_q <= load_w;
        sdo_q  <= load_w[SAMPLE_BITS-1];
      end else if (act_nxt) begin
        sdo_q <= pick_bit(word_q, nxt_bit_i);
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo_o = sdo_q;
  assign act_o = act_q;

  AST_POP_ONLY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> !empty_i); // R5
  AST_UNDERRUN_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> empty_i); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sdo_q); // R11
  AST_ACT_CHANGES_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(ev_i.wrap)); // R12
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
  import i2s_port_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 16,
  parameter int FIFO_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tick_ev_t              ev_i,
  input  logic [$clog2(SLOT_BITS)-1:0] cur_bit_i,
  input  logic                  en_i,
  input  logic                  sdi_i,
  input  logic                  full_i,
  output logic                  wr_o,
  output logic                  overrun_o,
  output logic [FIFO_W-1:0]     data_o,
  output logic                  act_o
);
  localparam int SP_W  = $clog2(SLOT_BITS);
  localparam int PAD_W = FIFO_W - SAMPLE_BITS;
  localparam logic [SP_W-1:0] SLOT_END = SP_W'(SLOT_BITS - 1);

  logic                   act_q, due_w, in_data_w, unused_ev;
  logic [SAMPLE_BITS-1:0] sh_q;

  assign in_data_w = int'(cur_bit_i) < SAMPLE_BITS;
  assign due_w     = ev_i.fall & act_q & (cur_bit_i == SLOT_END);
  assign wr_o      = due_w & ~full_i;
  assign overrun_o = due_w & full_i;
  assign data_o    = {sh_q, {PAD_W{1'b0}}};
  assign unused_ev = ev_i.slot_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      if (ev_i.rise && act_q && in_data_w) sh_q <= {sh_q[SAMPLE_BITS-2:0], sdi_i};
      if (ev_i.wrap) act_q <= en_i;
    end
  end

  assign act_o = act_q;

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> !full_i); // R8
  AST_PUSH_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (cur_bit_i == SLOT_END && ev_i.fall)); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && overrun_o)); // R8
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2s_port_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 16,
  parameter int FIFO_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en_i,
  input  logic              bclk_inv_i,
  input  logic              lrck_inv_i,
  input  logic              lrck_cont_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic [FIFO_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_rd_o,
  output logic              tx_underrun_o,
  input  logic              rx_sdi_i,
  output logic [FIFO_W-1:0] rx_data_o,
  input  logic              rx_full_i,
  output logic              rx_wr_o,
  output logic              rx_overrun_o,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              sdo_o,
  output logic              idle_o
);
  localparam int SP_W = $clog2(SLOT_BITS);

  tick_ev_t        ev;
  logic [SP_W-1:0] cur_bit, nxt_bit;
  logic            phase, ws, keep, tx_act, rx_act;

  assign keep = tx_en_i | rx_en_i | lrck_cont_i;

  i2s_timebase #(.SLOT_BITS(SLOT_BITS)) u_time (
    .clk(clk), .rst_n(rst_n), .bclk_en_i(bclk_en_i), .keep_i(keep),
    .ev_o(ev), .cur_bit_o(cur_bit), .nxt_bit_o(nxt_bit),
    .phase_o(phase), .ws_o(ws)
  );

  i2s_tx_lane #(.SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS), .FIFO_W(FIFO_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .nxt_bit_i(nxt_bit), .en_i(tx_en_i),
    .data_i(tx_data_i), .empty_i(tx_empty_i), .rd_o(tx_rd_o),
    .underrun_o(tx_underrun_o), .sdo_o(sdo_o), .act_o(tx_act)
  );

  i2s_rx_lane #(.SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS), .FIFO_W(FIFO_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .cur_bit_i(cur_bit), .en_i(rx_en_i),
    .sdi_i(rx_sdi_i), .full_i(rx_full_i), .wr_o(rx_wr_o),
    .overrun_o(rx_overrun_o), .data_o(rx_data_o), .act_o(rx_act)
  );

  assign bclk_o = phase ^ bclk_inv_i;
  assign lrck_o = ws ^ lrck_inv_i;
  assign idle_o = ~(tx_act | rx_act | tx_en_i | rx_en_i);

  AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!tx_rd_o && !rx_wr_o && !sdo_o)); // R10
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_rd_o && tx_underrun_o)); // R6
endmodule

// File: tb/tb_i2s_master_port.sv
module tb_i2s_master_port;
  localparam int FB = 64;
  localparam int SB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_en = 0, binv = 0, linv = 0, cont = 0, tx_en = 0, rx_en = 0;
  logic [31:0] tx_data = '0;
  logic tx_empty = 1, rx_sdi = 0, rx_full = 0;
  logic tx_rd, tx_und, rx_wr, rx_ovr, bclk, lrck, sdo, idle;
  logic [31:0] rx_data;

  always #5 clk = ~clk;

  i2s_master_port dut (
    .clk(clk), .rst_n(rst_n), .bclk_en_i(bclk_en), .bclk_inv_i(binv),
    .lrck_inv_i(linv), .lrck_cont_i(cont), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_data_i(tx_data), .tx_empty_i(tx_empty), .tx_rd_o(tx_rd),
    .tx_underrun_o(tx_und), .rx_sdi_i(rx_sdi), .rx_data_o(rx_data),
    .rx_full_i(rx_full), .rx_wr_o(rx_wr), .rx_overrun_o(rx_ovr),
    .bclk_o(bclk), .lrck_o(lrck), .sdo_o(sdo), .idle_o(idle)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // scenario controls
  bit s_tx = 0, s_rx = 0, s_cont = 0, s_binv = 0, s_linv = 0;
  int tick_mode = 1, rx_depth = 8, phase_cnt = 0;

  // FIFO models
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];

  // event counters
  int n_rd = 0, n_und = 0, n_wr = 0, n_ovr = 0, n_lr = 0, n_bclk = 0;
  int first_rd_lr = -1;
  logic prev_lr = 0, prev_bclk = 0;

  // reference model state
  int m_pos = FB - 1;
  bit m_hi = 0, m_run = 0, m_txa = 0, m_rxa = 0, m_sdo = 0;
  logic [15:0] m_word = '0, m_rxs = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit ws_of(input int p);
    return ((p + 1) % FB) >= SB;
  endfunction

  // one system clock of stimulus, model and comparison
  task automatic cycle();
    bit fall, rise, wrap, keep, stp, sopen, ntxa, nrxa, e_rd, e_und, push, full_now;
    int npos;
    logic [31:0] head;
    @(negedge clk);
    // registered outputs against model
    chk(bclk == (m_hi ^ binv), "R2", "bclk", bclk, m_hi ^ binv);
    chk(lrck == (ws_of(m_pos) ^ linv), "R3", "lrck", lrck, ws_of(m_pos) ^ linv);
    chk(sdo == m_sdo, "R4", "sdo", sdo, m_sdo);
    chk(idle == !(m_txa || m_rxa || tx_en || rx_en), "R10", "idle", idle,
        !(m_txa || m_rxa || tx_en || rx_en));
    if (lrck != prev_lr) n_lr++;
    if (bclk != prev_bclk) n_bclk++;
    prev_lr = lrck; prev_bclk = bclk;
    // drive inputs
    tx_en = s_tx; rx_en = s_rx; cont = s_cont; binv = s_binv; linv = s_linv;
    phase_cnt++;
    case (tick_mode)
      0: bclk_en = 1'b1;
      1: bclk_en = phase_cnt[0];
      default: bclk_en = 1'($urandom_range(0, 1));
    endcase
    tx_empty = (tx_q.size() == 0);
    head = tx_empty ? 32'h0 : tx_q[0];
    tx_data = tx_empty ? 32'hDEAD_0000 : tx_q[0];
    rx_full = (rx_q.size() >= rx_depth);
    rx_sdi = 1'($urandom_range(0, 1));
    #1;
    fall = m_run && bclk_en && m_hi;
    rise = m_run && bclk_en && !m_hi;
    wrap = fall && (m_pos == FB - 1);
    keep = tx_en || rx_en || cont;
    stp = wrap && !keep;
    npos = stp ? m_pos : (m_pos + 1) % FB;
    sopen = fall && !stp && (npos % SB == 0);
    ntxa = wrap ? tx_en : m_txa;
    nrxa = wrap ? rx_en : m_rxa;
    e_rd = sopen && ntxa && !tx_empty;
    e_und = sopen && ntxa && tx_empty;
    push = fall && m_rxa && (m_pos % SB == SB - 1);
    full_now = rx_full;
    chk(tx_rd == e_rd, "R5 R12", "tx_rd", tx_rd, e_rd);
    chk(tx_und == e_und, "R6", "tx_underrun", tx_und, e_und);
    chk(rx_wr == (push && !full_now), "R7", "rx_wr", rx_wr, push && !full_now);
    chk(rx_ovr == (push && full_now), "R8", "rx_overrun", rx_ovr, push && full_now);
    if (push && !full_now)
      chk(rx_data == {m_rxs, 16'h0}, "R7", "rx_data", rx_data, {m_rxs, 16'h0});
    if (tx_rd) begin
      n_rd++;
      if (first_rd_lr < 0) first_rd_lr = int'(lrck ^ linv);
    end
    if (tx_und) n_und++;
    if (rx_wr) begin n_wr++; rx_q.push_back(rx_data); end
    if (rx_ovr) n_ovr++;
    if (e_rd) void'(tx_q.pop_front());
    // model state update at the coming edge
    if (!m_run && keep) m_run = 1;
    if (rise) begin
      m_hi = 1;
      if (m_rxa && (m_pos % SB) < 16) m_rxs = {m_rxs[14:0], rx_sdi};
    end
    if (fall) begin
      m_hi = 0;
      m_pos = npos;
      if (stp) m_run = 0;
      m_txa = ntxa;
      m_rxa = nrxa;
      if (sopen && ntxa) begin
        m_word = e_rd ? head[31:16] : 16'h0;
        m_sdo = m_word[15];
      end else if (ntxa && (npos % SB) < 16) begin
        m_sdo = m_word[15 - (npos % SB)];
      end else begin
        m_sdo = 0;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic clear_counts();
    n_rd = 0; n_und = 0; n_wr = 0; n_ovr = 0; n_lr = 0; n_bclk = 0; first_rd_lr = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bclk == 1'b0, "R1", "bclk reset", bclk, 0);
    chk(lrck == 1'b0, "R1", "lrck reset", lrck, 0);
    chk(sdo == 1'b0, "R1", "sdo reset", sdo, 0);
    chk(idle == 1'b1, "R1", "idle reset", idle, 1);
    chk(!tx_rd && !tx_und && !rx_wr && !rx_ovr, "R1", "strobes reset",
        {tx_rd, tx_und, rx_wr, rx_ovr}, 0);

    // transmit only, regular divider
    for (int i = 0; i < 5; i++) tx_q.push_back({16'hA500 + 16'(i * 16'h1357), 16'h00FF});
    tick_mode = 1; s_tx = 1;
    run(3 * 256 + 60);
    chk(n_rd == 5, "R5", "pops in tx run", n_rd, 5);
    chk(n_und > 0, "R6", "underruns seen", n_und, 1);
    chk(n_wr == 0 && n_ovr == 0, "R9", "no rx traffic in tx-only", n_wr + n_ovr, 0);
    s_tx = 0;
    run(300);
    chk(idle == 1'b1, "R10", "idle after tx stop", idle, 1);
    clear_counts();
    run(40);
    chk(n_bclk == 0 && n_lr == 0, "R10", "clocks stopped", n_bclk + n_lr, 0);

    // receive only, inverted pins, random divider, small FIFO
    clear_counts();
    s_binv = 1; s_linv = 1; tick_mode = 2; rx_depth = 3; s_rx = 1;
    run(700);
    chk(n_wr == 3, "R7", "rx writes until full", n_wr, 3);
    chk(n_ovr >= 1, "R8", "overrun seen", n_ovr, 1);
    chk(n_rd == 0 && n_und == 0, "R9", "no tx traffic in rx-only", n_rd + n_und, 0);
    s_rx = 0;
    run(900);
    chk(idle == 1'b1, "R10", "idle after rx stop", idle, 1);

    // full duplex at the fastest rate
    rx_q.delete(); rx_depth = 16; clear_counts();
    s_binv = 0; s_linv = 0; tick_mode = 0;
    for (int i = 0; i < 4; i++) tx_q.push_back({16'h8001 ^ 16'(i * 16'h0F0F), 16'h1234});
    s_tx = 1; s_rx = 1;
    run(300);
    chk(n_rd == 4, "R5", "duplex pops", n_rd, 4);
    chk(n_wr >= 4, "R7", "duplex writes", n_wr, 4);
    s_tx = 0; s_rx = 0;
    run(200);

    // continuous clocks with both directions off
    clear_counts(); tick_mode = 1; s_cont = 1;
    run(301);
    chk(n_lr >= 2, "R11", "lrck toggles while off", n_lr, 2);
    chk(n_rd + n_und + n_wr + n_ovr == 0, "R11", "no fifo traffic", n_rd + n_und + n_wr + n_ovr, 0);
    chk(idle == 1'b1, "R11", "idle in continuous mode", idle, 1);

    // late start while clocks run
    clear_counts(); s_linv = 1;
    tx_q.push_back(32'hC3C3_0000); tx_q.push_back(32'h5A5A_0000);
    s_tx = 1;
    run(400);
    chk(first_rd_lr == 0, "R12", "first pop in left slot", first_rd_lr, 0);
    chk(n_rd == 2, "R12", "late-start pops", n_rd, 2);
    s_tx = 0; s_cont = 0;
    run(600);
    chk(idle == 1'b1, "R10", "idle at end", idle, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule